// File: doc/BRIEF.md
# Two-Dimensional Parity Codec with Single-Bit Repair

This block guards fixed-size blocks of data words with a row and column parity scheme. A transmit path tags every word with its own row parity bit and, once a block of words has gone by, emits one extra word holding the column parity of the block. Each bit of that extra word covers one bit position across all the words. A receive path takes such a block back in, holds the data words, and recomputes both parities. It then decides whether the block is intact, whether one data bit can be located and repaired, or whether the damage cannot be undone.

A lone flipped data bit upsets exactly one row check and exactly one column check, and the bit at their crossing is the one that is inverted on the way out. If only a row parity bit or only the column word is damaged, the data itself is sound and is forwarded untouched. Several failing rows or several failing columns leave the data as received and flag the block as beyond repair. Both paths use a word-serial stream with a valid strobe and a marker on the first word of a block. The receive path replays the held words in order, one per cycle, and then gives a one-cycle status strobe.

Top module: `rc_parity_codec`

## Requirements
- R1: While reset is held and after it is released with no input, `tx_out_valid`, `rx_out_valid` and `rx_stat_valid` are low and `rx_status` reads 0.
- R2: Each accepted transmit word appears on `tx_out_data` one cycle later with `tx_out_col` low and `tx_out_par` set so that the word plus that bit has even parity.
- R3: One cycle after the 8th word of a transmit block is output, a column word equal to the bitwise XOR of the 8 data words is output with `tx_out_col` high and `tx_out_par` equal to the XOR of that word's bits. The source leaves at least one idle cycle after each block.
- R4: A transmit word with `tx_in_start` high begins a new block, so the column word covers only the 8 words from that marker on.
- R5: The receive path accepts 8 data words (each with its row bit on `rx_in_par`) and then one column word. Starting 2 cycles after the column word is accepted, it outputs the 8 words in their received order, one per cycle with `rx_out_valid` high. In the cycle after the last word, `rx_stat_valid` is high for exactly one cycle and `rx_status` carries the verdict: 0 clean, 1 repaired, 2 unrepairable. A block with no parity violation is output unchanged with status 0.
- R6: A block with exactly one failing row and exactly one failing column is output with the bit at that row and column inverted, and status 1.
- R7: A block whose only violation is one failing row (a damaged row parity bit) or one failing column (a damaged column word) is output unchanged, with status 1.
- R8: A block with two or more failing rows or two or more failing columns is output exactly as received, with status 2.
- R9: A receive word with `rx_in_start` high discards any partial block and starts a new one at word 0.
- R10: Receive inputs presented while a block is being output or its status is being given are ignored, and the next block is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit input word present |
| tx_in_start | input | 1 | Transmit word is the first of a block |
| tx_in_data | input | DATA_W | Transmit data word |
| tx_out_valid | output | 1 | Transmit output word present |
| tx_out_data | output | DATA_W | Transmit output word (data or column word) |
| tx_out_par | output | 1 | Parity bit for the output word |
| tx_out_col | output | 1 | High when the output word is the column word |
| rx_in_valid | input | 1 | Receive input word present |
| rx_in_start | input | 1 | Receive word is the first of a block |
| rx_in_data | input | DATA_W | Receive data or column word |
| rx_in_par | input | 1 | Row parity bit of the receive data word |
| rx_out_valid | output | 1 | Repaired receive word present |
| rx_out_data | output | DATA_W | Repaired receive word |
| rx_stat_valid | output | 1 | One-cycle strobe with the block verdict |
| rx_status | output | 2 | Verdict: 0 clean, 1 repaired, 2 unrepairable |

## Verification
The bench targets the cases where row and column verdicts disagree. If only a row bit or only the column word is damaged, a design that repairs anyway would flip a good data bit. Two errors in one row cancel in the row check, so a design that looked only at rows would call the block clean. Two errors in separate rows and columns would have a wrong bit inverted by a design that repaired on any failing pair. A restart marker in the middle of a block and input noise during the replay would corrupt the held words or shift their order in a design that kept accepting writes.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

   typedef enum logic [1:0] {
      RCP_CLEAN = 2'd0,
      RCP_FIXED = 2'd1,
      RCP_FATAL = 2'd2
   } rcp_status_e;

   typedef enum logic [1:0] {
      D_RECV = 2'd0,
      D_SEND = 2'd1,
      D_STAT = 2'd2
   } rcp_dstate_e;

endpackage

// File: rtl/rcp_parity_bit.sv
module rcp_parity_bit #(
   parameter int W       = 8,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic [W-1:0] d,
   output logic         p
);
   generate
      if (ODD_PAR) begin : g_odd
         assign p = ~(^d);
      end else begin : g_even
         assign p = ^d;
      end
   endgenerate
endmodule

// File: rtl/rcp_encoder.sv
module rcp_encoder #(
   parameter int W       = 8,
   parameter int N       = 8,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         out_par,
   output logic         out_col
);
   localparam int CNT_W = $clog2(N + 1);
   localparam logic [CNT_W-1:0] BLK = CNT_W'(N);
   localparam logic [W-1:0] COL_FLIP = {W{ODD_PAR}};

   logic [W-1:0]     acc;
   logic [CNT_W-1:0] cnt;
   logic             pend;
   logic             first;
   logic [W-1:0]     acc_nx;
   logic [CNT_W-1:0] cnt_nx;
   logic [W-1:0]     col_word;
   logic             p_in;
   logic             p_col;

   assign first    = in_start || (cnt == '0);
   assign acc_nx   = first ? in_data : (acc ^ in_data);
   assign cnt_nx   = first ? CNT_W'(1) : (cnt + CNT_W'(1));
   assign col_word = acc ^ COL_FLIP;

   rcp_parity_bit #(.W(W), .ODD_PAR(ODD_PAR)) u_par_in (
      .d (in_data),
      .p (p_in)
   );

   rcp_parity_bit #(.W(W), .ODD_PAR(ODD_PAR)) u_par_col (
      .d (col_word),
      .p (p_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         cnt       <= '0;
         pend      <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_par   <= 1'b0;
         out_col   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_col   <= 1'b0;
         if (pend) begin
            out_valid <= 1'b1;
            out_data  <= col_word;
            out_par   <= p_col;
            out_col   <= 1'b1;
            pend      <= 1'b0;
         end else if (in_valid) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_par   <= p_in;
            acc       <= acc_nx;
            if (cnt_nx == BLK) begin
               pend <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt <= cnt_nx;
            end
         end
      end
   end
endmodule

// File: rtl/rcp_classifier.sv
module rcp_classifier
   import rcp_pkg::*;
#(
   parameter int W = 8,
   parameter int N = 8
) (
   input  logic [N-1:0] row_fail,
   input  logic [W-1:0] col_fail,
   output rcp_status_e  status,
   output logic         fix_en
);
   localparam int RC_W = $clog2(N + 1);
   localparam int CC_W = $clog2(W + 1);

   logic [RC_W-1:0] n_row;
   logic [CC_W-1:0] n_col;
   logic            row_many;
   logic            col_many;
   logic            row_none;
   logic            col_none;

   always_comb begin
      n_row = '0;
      for (int i = 0; i < N; i++) begin
         n_row = n_row + RC_W'(row_fail[i]);
      end
   end

   always_comb begin
      n_col = '0;
      for (int j = 0; j < W; j++) begin
         n_col = n_col + CC_W'(col_fail[j]);
      end
   end

   assign row_many = n_row > RC_W'(1);
   assign col_many = n_col > CC_W'(1);
   assign row_none = n_row == '0;
   assign col_none = n_col == '0;

   always_comb begin
      if (row_many || col_many) begin
         status = RCP_FATAL;
      end else if (row_none && col_none) begin
         status = RCP_CLEAN;
      end else begin
         status = RCP_FIXED;
      end
   end

   assign fix_en = !row_many && !col_many && !row_none && !col_none;
endmodule

// File: rtl/rcp_decoder.sv
module rcp_decoder
   import rcp_pkg::*;
#(
   parameter int W       = 8,
   parameter int N       = 8,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_start,
   input  logic [W-1:0] in_data,
   input  logic         in_par,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   output logic         stat_valid,
   output logic [1:0]   status
);
   localparam int CNT_W = $clog2(N + 1);
   localparam int IDX_W = $clog2(N);
   localparam logic [CNT_W-1:0] BLK = CNT_W'(N);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
   localparam logic [W-1:0] COL_FLIP = {W{ODD_PAR}};

   rcp_dstate_e      state;
   logic [W-1:0]     mem [N];
   logic [N-1:0]     rowf;
   logic [W-1:0]     colf;
   logic [W-1:0]     acc;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic             first;
   logic             take_data;
   logic [IDX_W-1:0] wr_idx;
   logic             p_in;
   logic             row_bad;
   logic [W-1:0]     colf_nx;
   rcp_status_e      verdict;
   logic             fix_en;
   logic [W-1:0]     fix_mask;
   logic [W-1:0]     fixed_word;

   rcp_parity_bit #(.W(W), .ODD_PAR(ODD_PAR)) u_par_in (
      .d (in_data),
      .p (p_in)
   );

   rcp_classifier #(.W(W), .N(N)) u_cls (
      .row_fail (rowf),
      .col_fail (colf),
      .status   (verdict),
      .fix_en   (fix_en)
   );

   assign first      = in_start || (cnt == '0);
   assign take_data  = (state == D_RECV) && in_valid && (first || (cnt < BLK));
   assign wr_idx     = first ? '0 : IDX_W'(cnt);
   assign row_bad    = p_in ^ in_par;
   assign colf_nx    = acc ^ in_data ^ COL_FLIP;
   assign fix_mask   = colf & {W{fix_en & rowf[idx]}};
   assign fixed_word = mem[idx] ^ fix_mask;

   always_ff @(posedge clk) begin
      if (take_data) begin
         mem[wr_idx] <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= D_RECV;
         rowf       <= '0;
         colf       <= '0;
         acc        <= '0;
         cnt        <= '0;
         idx        <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         stat_valid <= 1'b0;
         status     <= 2'd0;
      end else begin
         out_valid  <= 1'b0;
         stat_valid <= 1'b0;
         case (state)
            D_RECV: begin
               if (in_valid) begin
                  if (first) begin
                     rowf <= {{(N-1){1'b0}}, row_bad};
                     acc  <= in_data;
                     cnt  <= CNT_W'(1);
                  end else if (cnt < BLK) begin
                     rowf[wr_idx] <= row_bad;
                     acc          <= acc ^ in_data;
                     cnt          <= cnt + CNT_W'(1);
                  end else begin
                     colf  <= colf_nx;
                     cnt   <= '0;
                     idx   <= '0;
                     state <= D_SEND;
                  end
               end
            end
            D_SEND: begin
               out_valid <= 1'b1;
               out_data  <= fixed_word;
               if (idx == LAST_IDX) begin
                  state <= D_STAT;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            D_STAT: begin
               stat_valid <= 1'b1;
               status     <= verdict;
               state      <= D_RECV;
            end
            default: state <= D_RECV;
         endcase
      end
   end
endmodule

// File: rtl/rc_parity_codec.sv
module rc_parity_codec #(
   parameter int DATA_W    = 8,
   parameter int BLK_WORDS = 8,
   parameter bit ODD_PAR   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_in_valid,
   input  logic              tx_in_start,
   input  logic [DATA_W-1:0] tx_in_data,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out_data,
   output logic              tx_out_par,
   output logic              tx_out_col,
   input  logic              rx_in_valid,
   input  logic              rx_in_start,
   input  logic [DATA_W-1:0] rx_in_data,
   input  logic              rx_in_par,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_data,
   output logic              rx_stat_valid,
   output logic [1:0]        rx_status
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("rc_parity_codec: DATA_W must be at least 2");
      end
      if (BLK_WORDS < 2) begin : g_bad_depth
         $error("rc_parity_codec: BLK_WORDS must be at least 2");
      end
   endgenerate

   rcp_encoder #(.W(DATA_W), .N(BLK_WORDS), .ODD_PAR(ODD_PAR)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (tx_in_valid),
      .in_start  (tx_in_start),
      .in_data   (tx_in_data),
      .out_valid (tx_out_valid),
      .out_data  (tx_out_data),
      .out_par   (tx_out_par),
      .out_col   (tx_out_col)
   );

   rcp_decoder #(.W(DATA_W), .N(BLK_WORDS), .ODD_PAR(ODD_PAR)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_in_valid),
      .in_start   (rx_in_start),
      .in_data    (rx_in_data),
      .in_par     (rx_in_par),
      .out_valid  (rx_out_valid),
      .out_data   (rx_out_data),
      .stat_valid (rx_stat_valid),
      .status     (rx_status)
   );
endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
   parameter int DATA_W  = 8,
   parameter bit ODD_PAR = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_out_valid,
   input logic [DATA_W-1:0] tx_out_data,
   input logic              tx_out_par,
   input logic              tx_out_col,
   input logic              rx_out_valid,
   input logic              rx_stat_valid,
   input logic [1:0]        rx_status
);
   AST_TX_ROW_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid |-> (((^tx_out_data) ^ tx_out_par) == ODD_PAR)); // R2

   AST_TX_COL_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_valid && tx_out_col) |-> ($past(tx_out_valid) && !$past(tx_out_col))); // R3

   AST_STAT_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_valid |-> $past(rx_out_valid)); // R5

   AST_STAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_valid |=> !rx_stat_valid); // R5

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_out_valid && rx_stat_valid)); // R5

   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stat_valid |-> (rx_status != 2'd3)); // R8
endmodule

bind rc_parity_codec rcp_checker #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_out_valid  (tx_out_valid),
   .tx_out_data   (tx_out_data),
   .tx_out_par    (tx_out_par),
   .tx_out_col    (tx_out_col),
   .rx_out_valid  (rx_out_valid),
   .rx_stat_valid (rx_stat_valid),
   .rx_status     (rx_status)
);

// File: tb/rc_parity_codec_test.sv
`timescale 1ns/1ps
module rc_parity_codec_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_in_valid = 1'b0;
   logic       tx_in_start = 1'b0;
   logic [7:0] tx_in_data = '0;
   logic       tx_out_valid;
   logic [7:0] tx_out_data;
   logic       tx_out_par;
   logic       tx_out_col;
   logic       rx_in_valid = 1'b0;
   logic       rx_in_start = 1'b0;
   logic [7:0] rx_in_data = '0;
   logic       rx_in_par = 1'b0;
   logic       rx_out_valid;
   logic [7:0] rx_out_data;
   logic       rx_stat_valid;
   logic [1:0] rx_status;

   int nchk = 0;
   int nerr = 0;

   logic [7:0] sd [8];
   logic       sp [8];
   logic [7:0] scol;
   logic [7:0] ed [8];
   logic [1:0] estat;

   always #4 clk = ~clk;

   rc_parity_codec uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_in_valid   (tx_in_valid),
      .tx_in_start   (tx_in_start),
      .tx_in_data    (tx_in_data),
      .tx_out_valid  (tx_out_valid),
      .tx_out_data   (tx_out_data),
      .tx_out_par    (tx_out_par),
      .tx_out_col    (tx_out_col),
      .rx_in_valid   (rx_in_valid),
      .rx_in_start   (rx_in_start),
      .rx_in_data    (rx_in_data),
      .rx_in_par     (rx_in_par),
      .rx_out_valid  (rx_out_valid),
      .rx_out_data   (rx_out_data),
      .rx_stat_valid (rx_stat_valid),
      .rx_status     (rx_status)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] gen(input int seed, input int i);
      return 8'((seed * 37 + i * 73 + 5) ^ (seed * i));
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check(!tx_out_valid, "R1 tx_out_valid", 32'(tx_out_valid), 0);
      check(!rx_out_valid, "R1 rx_out_valid", 32'(rx_out_valid), 0);
      check(!rx_stat_valid && rx_status == 2'd0, "R1 status", 32'({rx_stat_valid, rx_status}), 0);
   endtask

   task automatic tx_block(input int seed, input int pre, input string req);
      logic [7:0] w [8];
      logic [7:0] col;
      col = '0;
      for (int j = 0; j < pre; j++) begin
         @(negedge clk);
         tx_in_valid = 1'b1;
         tx_in_start = (j == 0);
         tx_in_data  = gen(seed + 50, j);
      end
      for (int i = 0; i < 8; i++) begin
         w[i] = gen(seed, i);
         col  = col ^ w[i];
         @(negedge clk);
         if (i > 0) begin
            check(tx_out_valid && !tx_out_col && tx_out_data == w[i-1] && tx_out_par == ^w[i-1],
                  "R2 tx word", 32'({tx_out_valid, tx_out_col, tx_out_par, tx_out_data}),
                  32'({1'b1, 1'b0, ^w[i-1], w[i-1]}));
         end
         tx_in_valid = 1'b1;
         tx_in_start = (i == 0);
         tx_in_data  = w[i];
      end
      @(negedge clk);
      check(tx_out_valid && !tx_out_col && tx_out_data == w[7], "R2 tx last word",
            32'({tx_out_valid, tx_out_col, tx_out_data}), 32'({1'b1, 1'b0, w[7]}));
      tx_in_valid = 1'b0;
      tx_in_start = 1'b0;
      @(negedge clk);
      check(tx_out_valid && tx_out_col && tx_out_data == col && tx_out_par == ^col, req,
            32'({tx_out_valid, tx_out_col, tx_out_par, tx_out_data}),
            32'({1'b1, 1'b1, ^col, col}));
      @(negedge clk);
      check(!tx_out_valid, "R3 tx idle after column word", 32'(tx_out_valid), 0);
   endtask

   task automatic fill_clean(input int seed);
      scol = '0;
      for (int i = 0; i < 8; i++) begin
         sd[i] = gen(seed, i);
         sp[i] = ^sd[i];
         ed[i] = sd[i];
         scol  = scol ^ sd[i];
      end
      estat = 2'd0;
   endtask

   task automatic rx_run(input int pre, input bit noise, input string req);
      for (int j = 0; j < pre; j++) begin
         @(negedge clk);
         rx_in_valid = 1'b1;
         rx_in_start = (j == 0);
         rx_in_data  = 8'(8'hC3 + j);
         rx_in_par   = 1'b1;
      end
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rx_in_valid = 1'b1;
         rx_in_start = (i == 0);
         rx_in_data  = sd[i];
         rx_in_par   = sp[i];
      end
      @(negedge clk);
      rx_in_start = 1'b0;
      rx_in_data  = scol;
      rx_in_par   = 1'b0;
      @(negedge clk);
      check(!rx_out_valid, {req, " no early word"}, 32'(rx_out_valid), 0);
      if (noise) begin
         rx_in_valid = 1'b1;
         rx_in_start = 1'b1;
         rx_in_data  = 8'hA5;
         rx_in_par   = 1'b1;
      end else begin
         rx_in_valid = 1'b0;
      end
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check(rx_out_valid && rx_out_data == ed[i], {req, " word"},
               32'({rx_out_valid, rx_out_data}), 32'({1'b1, ed[i]}));
         if (noise) begin
            rx_in_data  = 8'(~i);
            rx_in_start = i[0];
         end
      end
      @(negedge clk);
      check(rx_stat_valid && !rx_out_valid && rx_status == estat, {req, " status"},
            32'({rx_stat_valid, rx_out_valid, rx_status}), 32'({1'b1, 1'b0, estat}));
      rx_in_valid = 1'b0;
      rx_in_start = 1'b0;
      @(negedge clk);
      check(!rx_stat_valid && !rx_out_valid, "R5 status one cycle",
            32'({rx_stat_valid, rx_out_valid}), 0);
   endtask

   task automatic t_rx_clean();
      fill_clean(3);
      rx_run(0, 1'b0, "R5 clean");
   endtask

   task automatic t_rx_single();
      fill_clean(7);
      sd[5] = sd[5] ^ 8'h08;
      estat = 2'd1;
      rx_run(0, 1'b0, "R6 single repair");
      fill_clean(11);
      sd[0] = sd[0] ^ 8'h80;
      estat = 2'd1;
      rx_run(0, 1'b0, "R6 corner repair");
   endtask

   task automatic t_rx_parbits();
      fill_clean(13);
      sp[2] = ~sp[2];
      estat = 2'd1;
      rx_run(0, 1'b0, "R7 row bit only");
      fill_clean(17);
      scol  = scol ^ 8'h40;
      estat = 2'd1;
      rx_run(0, 1'b0, "R7 column word only");
   endtask

   task automatic t_rx_multi();
      fill_clean(19);
      sd[1] = sd[1] ^ 8'h01;
      sd[6] = sd[6] ^ 8'h80;
      for (int i = 0; i < 8; i++) ed[i] = sd[i];
      estat = 2'd2;
      rx_run(0, 1'b0, "R8 two rows two columns");
      fill_clean(23);
      sd[3] = sd[3] ^ 8'h11;
      for (int i = 0; i < 8; i++) ed[i] = sd[i];
      estat = 2'd2;
      rx_run(0, 1'b0, "R8 two columns one row");
   endtask

   task automatic t_rx_restart();
      fill_clean(29);
      rx_run(4, 1'b0, "R9 restart marker");
   endtask

   task automatic t_rx_noise();
      fill_clean(31);
      sd[4] = sd[4] ^ 8'h02;
      estat = 2'd1;
      rx_run(0, 1'b1, "R10 input during replay");
      fill_clean(37);
      rx_run(0, 1'b0, "R10 next block after noise");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_reset();
      tx_block(1, 0, "R3 column word");
      tx_block(5, 3, "R4 column after restart");
      t_rx_clean();
      t_rx_single();
      t_rx_parbits();
      t_rx_multi();
      t_rx_restart();
      t_rx_noise();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule